// File: doc/BRIEF.md
# Indirect SDRAM controller register bank

This block is the configuration and status register file of a DDR SDRAM memory controller. A device-control bus reaches it through two ports only: a window-address port that holds an internal register offset, and a window-data port that reads or writes whichever internal register that offset selects. Software sets the offset once and can then make several data accesses to that register.

The registers are:
- two sticky bus-error status words, which hardware sets and software clears by writing ones;
- an error address word;
- a control word whose top bits enable the memory and request self-refresh, with a read-only status word that follows those bits;
- refresh, power-management and timing words, each with its own write mask;
- four bank words;
- an ECC control word and an ECC error word, which drives a level interrupt.

Bank writes are forwarded to a separate mapping unit as one-cycle pulses, together with the current enable bit.

Top module: `sdram_regbank`

## Requirements
- R1: After reset: the window offset, error address, both error status words, ECC control, ECC error word and status read 0. Power management reads 0x07C00000, refresh reads 0x05F00000 and control reads 0x00800000. The interrupt is low and no bank pulse is active.
- R2: A write with `win_sel`=0 latches the 32-bit offset. A read with `win_sel`=0 returns it. With `win_sel`=1, reads and writes reach the register at the latched offset.
- R3: The error status words sit at offsets 0x00 and 0x08. Each bit is set by its `err_set` input. A data write clears the bits that are 1 in the written value. A set on the same cycle wins over a clear.
- R4: The error address word (0x10) stores the written value unchanged.
- R5: A control write (0x20) keeps only bits 31..21 (mask 0xFFE00000).
- R6: Control bit 31 drives `mem_enable`. On a write that takes it from 0 to 1, status bit 31 (status at 0x24) clears. On a write that takes it from 1 to 0, status bit 31 sets.
- R7: Status bit 30 copies control bit 30 and changes only on a control write that changes that bit.
- R8: Writes to the status offset 0x24 have no effect.
- R9: The write masks are:
  - refresh (0x30): value AND 0x3FF80000;
  - power management (0x34): (value AND 0xF8000000) OR 0x07C00000;
  - ECC control (0x94): value AND 0x00F00000;
  - ECC error (0x98): value AND 0xFFF0F000.
- R10: `ecc_irq` rises when a masked ECC error write turns that word from zero to nonzero. It falls when a write turns it from nonzero to zero. Otherwise it holds.
- R11: Data reads at the timing offset 0x80 and at any undefined offset return 0xFFFFFFFF. Data writes to undefined offsets change nothing.
- R12: The bank words at 0x40, 0x44, 0x48 and 0x4C (banks 0 to 3) store full 32-bit values. `bank_upd[i]` pulses for exactly one cycle after a write to bank i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_sel | input | 1 | 0 selects the offset port, 1 the data port |
| win_we | input | 1 | Write strobe, one cycle per write |
| win_wdata | input | 32 | Write data |
| win_rdata | output | 32 | Combinational read data for the selected port |
| err_set0 | input | 32 | Set bits for error status word 0 |
| err_set1 | input | 32 | Set bits for error status word 1 |
| mem_enable | output | 1 | Current control bit 31 |
| bank_upd | output | 4 | One-cycle pulse per written bank |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
The bench aims at the edge behaviour of the status word. A design that keyed status bit 31 to the level of control bit 31, rather than to its edges, would get the status wrong after a repeated enable write. The bench also drives ECC error writes whose masked value is zero or unchanged, which catches an interrupt tied to the raw value or to every write. It checks that the forced bits of the power-management word survive a write of zero. It checks that a same-cycle set and clear keeps the set bit, and that timing and unmapped reads return all ones, where a design that decoded too few address bits would alias them.

// File: rtl/sdram_regbank.sv
module sdram_regbank #(
  parameter int DW    = 32,
  parameter int NBANK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_sel,
  input  logic          win_we,
  input  logic [DW-1:0] win_wdata,
  output logic [DW-1:0] win_rdata,
  input  logic [DW-1:0] err_set0,
  input  logic [DW-1:0] err_set1,
  output logic          mem_enable,
  output logic [NBANK-1:0] bank_upd,
  output logic          ecc_irq
);
  localparam logic [DW-1:0] OFF_ERR0 = 'h00, OFF_ERR1 = 'h08, OFF_EADR = 'h10;
  localparam logic [DW-1:0] OFF_CTL  = 'h20, OFF_STAT = 'h24, OFF_RFSH = 'h30;
  localparam logic [DW-1:0] OFF_PWR  = 'h34, OFF_BANK = 'h40, OFF_TIM  = 'h80;
  localparam logic [DW-1:0] OFF_ECFG = 'h94, OFF_EERR = 'h98;
  localparam logic [DW-1:0] ALL1     = '1;

  logic [DW-1:0] offs, err0, err1, eadr, ctl, stat, rfsh, pwr, ecfg, eerr;
  logic [DW-1:0] bank_q [NBANK];
  logic [NBANK-1:0] bank_hit;

  wire dwr = win_we & win_sel;
  wire [DW-1:0] ctl_new  = win_wdata & 32'hFFE0_0000;
  wire [DW-1:0] eerr_new = win_wdata & 32'hFFF0_F000;

  assign mem_enable = ctl[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offs <= '0; err0 <= '0; err1 <= '0; eadr <= '0; stat <= '0;
      ecfg <= '0; eerr <= '0; ecc_irq <= 1'b0;
      ctl  <= 32'h0080_0000;
      rfsh <= 32'h05F0_0000;
      pwr  <= 32'h07C0_0000;
    end else begin
      err0 <= (err0 & ~((dwr && offs == OFF_ERR0) ? win_wdata : '0)) | err_set0;
      err1 <= (err1 & ~((dwr && offs == OFF_ERR1) ? win_wdata : '0)) | err_set1;
      if (win_we && !win_sel) offs <= win_wdata;
      if (dwr) begin
        case (offs)
          OFF_EADR: eadr <= win_wdata;
          OFF_CTL: begin
            if (!ctl[31] && ctl_new[31]) stat[31] <= 1'b0;
            else if (ctl[31] && !ctl_new[31]) stat[31] <= 1'b1;
            if (ctl[30] != ctl_new[30]) stat[30] <= ctl_new[30];
            ctl <= ctl_new;
          end
          OFF_RFSH: rfsh <= win_wdata & 32'h3FF8_0000;
          OFF_PWR:  pwr  <= (win_wdata & 32'hF800_0000) | 32'h07C0_0000;
          OFF_ECFG: ecfg <= win_wdata & 32'h00F0_0000;
          OFF_EERR: begin
            if (eerr == '0 && eerr_new != '0) ecc_irq <= 1'b1;
            else if (eerr != '0 && eerr_new == '0) ecc_irq <= 1'b0;
            eerr <= eerr_new;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [DW-1:0] BOFF = OFF_BANK + DW'(4 * i);
    assign bank_hit[i] = (offs == BOFF);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[i]   <= '0;
        bank_upd[i] <= 1'b0;
      end else begin
        bank_upd[i] <= dwr && bank_hit[i];
        if (dwr && bank_hit[i]) bank_q[i] <= win_wdata;
      end
    end
  end

  always_comb begin
    win_rdata = ALL1;
    if (!win_sel) win_rdata = offs;
    else begin
      case (offs)
        OFF_ERR0: win_rdata = err0;
        OFF_ERR1: win_rdata = err1;
        OFF_EADR: win_rdata = eadr;
        OFF_CTL:  win_rdata = ctl;
        OFF_STAT: win_rdata = stat;
        OFF_RFSH: win_rdata = rfsh;
        OFF_PWR:  win_rdata = pwr;
        OFF_TIM:  win_rdata = ALL1;
        OFF_ECFG: win_rdata = ecfg;
        OFF_EERR: win_rdata = eerr;
        default:  win_rdata = ALL1;
      endcase
      for (int j = 0; j < NBANK; j++)
        if (bank_hit[j]) win_rdata = bank_q[j];
    end
  end

  a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && offs == OFF_STAT) |=> $stable(stat));
  a_r6_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && offs == OFF_CTL && !mem_enable && win_wdata[31]) |=> !stat[31]);
  a_r6_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && offs == OFF_CTL && mem_enable && !win_wdata[31]) |=> stat[31]);
  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_irq == (eerr != '0));
  a_r9_pwr_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr & 32'h07C0_0000) == 32'h07C0_0000);
  a_r5_ctl_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[20:0] == '0);
  a_r12_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_upd));
  a_r12_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_upd != '0 && !dwr) |=> bank_upd == '0);
endmodule

// File: tb/sim_sdram_regbank.sv
`timescale 1ns/1ps
module sim_sdram_regbank;
  logic clk = 0, rst_n = 0, win_sel = 0, win_we = 0;
  logic [31:0] win_wdata = 0, err_set0 = 0, err_set1 = 0, win_rdata;
  logic mem_enable, ecc_irq;
  logic [3:0] bank_upd;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  sdram_regbank u0 (.clk, .rst_n, .win_sel, .win_we, .win_wdata, .win_rdata,
    .err_set0, .err_set1, .mem_enable, .bank_upd, .ecc_irq);

  // {req, offset, write value, expected readback}
  localparam int NV = 12;
  localparam logic [103:0] VEC [NV] = '{
    {8'd4,  32'h10, 32'hDEADBEEF, 32'hDEADBEEF},   // R4
    {8'd9,  32'h30, 32'hFFFFFFFF, 32'h3FF80000},   // R9
    {8'd9,  32'h34, 32'h00000000, 32'h07C00000},   // R9
    {8'd9,  32'h34, 32'hFFFFFFFF, 32'hFFC00000},   // R9
    {8'd11, 32'h80, 32'h12345678, 32'hFFFFFFFF},   // R11
    {8'd9,  32'h94, 32'hFFFFFFFF, 32'h00F00000},   // R9
    {8'd12, 32'h40, 32'hA5A5A5A5, 32'hA5A5A5A5},   // R12
    {8'd12, 32'h4C, 32'h01234567, 32'h01234567},   // R12
    {8'd5,  32'h20, 32'hFFFFFFFF, 32'hFFE00000},   // R5
    {8'd8,  32'h24, 32'h00000000, 32'h40000000},   // R8
    {8'd11, 32'h60, 32'h00000055, 32'hFFFFFFFF},   // R11
    {8'd11, 32'h41, 32'hCAFEF00D, 32'hFFFFFFFF}    // R11
  };

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); win_sel = sel; win_we = 1; win_wdata = d;
    @(negedge clk); win_we = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] off, input string req, input logic [31:0] exp);
    wr(0, off);
    win_sel = 1; #1;
    chk(req, win_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    win_sel = 0; #1; chk("R1 offset", win_rdata, 0);
    chk("R1 irq", {31'd0, ecc_irq}, 0);
    chk("R1 bank_upd", {28'd0, bank_upd}, 0);
    rd(32'h00, "R1 err0", 0);
    rd(32'h08, "R1 err1", 0);
    rd(32'h10, "R1 eaddr", 0);
    rd(32'h20, "R1 ctl", 32'h00800000);
    rd(32'h24, "R1 stat", 0);
    rd(32'h30, "R1 rfsh", 32'h05F00000);
    rd(32'h34, "R1 pwr", 32'h07C00000);
    rd(32'h94, "R1 ecfg", 0);
    rd(32'h98, "R1 eerr", 0);
    // R2 offset readback
    wr(0, 32'h0000_0098); win_sel = 0; #1; chk("R2 offset", win_rdata, 32'h98);

    for (int i = 0; i < NV; i++) begin
      wr(0, VEC[i][95:64]);
      wr(1, VEC[i][63:32]);
      win_sel = 1; #1;
      chk($sformatf("R%0d vec%0d", VEC[i][103:96], i), win_rdata, VEC[i][31:0]);
    end

    // R3 set then write-one-to-clear
    @(negedge clk); err_set0 = 32'h0000F00F; err_set1 = 32'h00000300;
    @(negedge clk); err_set0 = 0; err_set1 = 0;
    rd(32'h00, "R3 err0 set", 32'h0000F00F);
    wr(1, 32'h0000000F); #1; chk("R3 err0 clr", win_rdata, 32'h0000F000);
    rd(32'h08, "R3 err1 set", 32'h00000300);
    @(negedge clk); win_sel = 1; win_we = 1; win_wdata = 32'h00000300; err_set1 = 32'h00000100;
    @(negedge clk); win_we = 0; err_set1 = 0; #1;
    chk("R3 set wins", win_rdata, 32'h00000100);

    // R6/R7 control edges (control currently 0xFFE00000, status 0x40000000)
    rd(32'h20, "R6 enabled", 32'hFFE00000);
    chk("R6 mem_enable", {31'd0, mem_enable}, 1);
    wr(1, 32'h00000000);
    rd(32'h24, "R6 disable sets", 32'h80000000);
    chk("R6 mem_enable off", {31'd0, mem_enable}, 0);
    wr(0, 32'h20); wr(1, 32'h40000000);
    rd(32'h24, "R7 mirror on", 32'hC0000000);
    wr(0, 32'h20); wr(1, 32'h80000000);
    rd(32'h24, "R6 enable clears", 32'h00000000);
    wr(0, 32'h20); wr(1, 32'h80000000);
    rd(32'h24, "R6 repeat enable", 32'h00000000);

    // R10 interrupt
    wr(0, 32'h98); wr(1, 32'h00000FFF); #1;
    chk("R10 masked zero", {31'd0, ecc_irq}, 0);
    wr(1, 32'hFFFFFFFF); #1;
    chk("R10 eerr mask", win_rdata, 32'hFFF0F000);
    chk("R10 rise", {31'd0, ecc_irq}, 1);
    wr(1, 32'h00100000); #1;
    chk("R10 hold", {31'd0, ecc_irq}, 1);
    wr(1, 32'h0000_0001); #1;
    chk("R10 fall", {31'd0, ecc_irq}, 0);

    // R12 bank pulse
    wr(0, 32'h48);
    @(negedge clk); win_sel = 1; win_we = 1; win_wdata = 32'h11112222;
    @(negedge clk); win_we = 0; #1;
    chk("R12 pulse", {28'd0, bank_upd}, 32'h4);
    chk("R12 store", win_rdata, 32'h11112222);
    @(negedge clk); #1;
    chk("R12 pulse ends", {28'd0, bank_upd}, 0);

    // R11 undefined write left everything intact
    rd(32'h10, "R11 eaddr intact", 32'hDEADBEEF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule